// File: doc/BRIEF.md
# Serial Audio Converter Receiver with Programmable Word Placement

This block takes the three serial lines of an external audio converter (a bit clock, a frame clock that tells left from right, and a data line) and turns each left/right frame into a pair of parallel samples. All three lines are sampled in the system clock domain. A rising edge of the bit clock is found by comparing the current level with the level held from the previous system cycle, and each such edge shifts one data bit into a history register. A change in the frame-clock level closes the slot that was running.

The sample is not found by a fixed justification. Two configuration inputs set where it lies: a word length and a count of trailing bits to skip. When a slot closes, the word is taken from the history, ending the programmed number of bits before the slot boundary. It is then sign-extended to 32 bits. A left word is held until the following right slot closes, and then both are presented with a one-cycle valid strobe. A slot that is too short to hold the programmed word raises an error strobe, and its frame is dropped.

Top module: `adc_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `left_o` and `right_o` are zero and `valid_o` and `err_o` are low until a slot closes.
- R2: Data is sampled on each rising edge of `sck`, MSB first. `ws` low means the left slot and `ws` high means the right slot. The bit taken at the edge where `ws` has changed level is the first bit of the new slot, and that same edge closes the previous slot. The first edge after reset opens a slot without closing one.
- R3: The word holds `cfg_wlen`+1 bits, so 0 to 31 selects 1 to 32 bits. The value 15 selects a 16-bit word.
- R4: The last bit of the word lies `cfg_wpos` bit periods before the slot boundary. With `cfg_wpos` = 0, the word ends on the final bit of the slot.
- R5: Each output sample is the extracted word sign-extended to 32 bits, with the word's MSB copied into all upper bits.
- R6: One system cycle after the edge that closes a right slot, `valid_o` is high for exactly one cycle, provided the slot just before it was a left slot. `left_o` holds that left word and `right_o` holds the right word. Between strobes, both outputs hold their values.
- R7: If a slot closes holding fewer than `cfg_wlen`+1+`cfg_wpos` bits, `err_o` pulses one cycle after the closing edge. No `valid_o` is given for the frame that contains that slot.
- R8: Bits before the word in a slot (leading bits) have no effect on the output, even when the slot is longer than 64 bits.
- R9: `cfg_wlen` and `cfg_wpos` are used at the moment a slot closes. A change that is made while a slot is running applies to that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial bit clock from the converter |
| ws | input | 1 | Frame clock: low = left slot, high = right slot |
| sd | input | 1 | Serial data, MSB first |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_wpos | input | 5 | Trailing bits to skip before the slot boundary |
| left_o | output | 32 | Sign-extended left sample |
| right_o | output | 32 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe: a new sample pair is on the outputs |
| err_o | output | 1 | One-cycle strobe: a slot was too short for the programmed word |

## Verification
Two kinds of internal fault look different at the ports. A bad history or bad bit count shows as a wrong sample value, a missing strobe, or a spurious error on the frame being received. It becomes visible one system cycle after the bit-clock edge that closes that slot. A lost or stale left word, or a wrong pairing state, shows at the next right-slot close as a mismatched pair or a missing or extra valid strobe. Every frame's result is therefore checked within one slot of the fault. The bench also compares the total count of strobes with the expected count, so that silently dropped frames are caught.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;
endpackage

// File: rtl/adc_rx_edge.sv
// Rising-edge detector for the bit clock, sampled in the system clock domain.
module adc_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);
    logic sck_d, sck_q;

    always_comb begin
        sck_d = sck;
        rise  = sck & ~sck_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_d;
    end
endmodule

// File: rtl/adc_rx_slot.sv
// Slot tracker: shifts bits into a history and closes a slot when the frame clock changes.
module adc_rx_slot
    import adc_rx_pkg::*;
#(
    parameter int HIST_W = 64,
    parameter int CNT_W  = $clog2(HIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              ws,
    input  logic              sd,
    output logic              close,
    output side_e             close_side,
    output logic [HIST_W-1:0] hist,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HIST_W);

    typedef struct packed {
        logic              started;
        side_e             side;
        logic [HIST_W-1:0] hist;
        logic [CNT_W-1:0]  cnt;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        close = 1'b0;
        if (rise) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], sd};
            if (!st_q.started) begin
                st_d.started = 1'b1;
                st_d.side    = side_e'(ws);
                st_d.cnt     = CNT_W'(1);
            end else if (side_e'(ws) != st_q.side) begin
                close        = 1'b1;
                st_d.side    = side_e'(ws);
                st_d.cnt     = CNT_W'(1);
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt     = st_q.cnt + CNT_W'(1);
            end
        end
        close_side = st_q.side;
        hist       = st_q.hist;
        cnt        = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_rx_extract.sv
// Pulls the programmed word out of the slot history and sign-extends it.
module adc_rx_extract #(
    parameter int OUT_W  = 32,
    parameter int LEN_W  = 5,
    parameter int HIST_W = 64,
    parameter int CNT_W  = $clog2(HIST_W + 1)
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [LEN_W-1:0]  wpos,
    output logic [OUT_W-1:0]  word,
    output logic              short_slot
);
    logic [HIST_W-1:0] aligned;
    logic [CNT_W-1:0]  need;

    always_comb begin
        aligned = hist >> wpos;
        need    = CNT_W'(wlen) + CNT_W'(wpos) + CNT_W'(1);
        short_slot = (cnt < need);
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        always_comb begin
            if (i <= int'(wlen)) word[i] = aligned[i];
            else                 word[i] = aligned[wlen];
        end
    end
endmodule

// File: rtl/adc_rx.sv
// Serial audio converter receiver: programmable word length and trailing-skip placement.
module adc_rx
    import adc_rx_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             ws,
    input  logic             sd,
    input  logic [LEN_W-1:0] cfg_wlen,
    input  logic [LEN_W-1:0] cfg_wpos,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o,
    output logic             err_o
);
    localparam int MAX_LEN = 2 ** LEN_W;
    localparam int HIST_W  = 2 * MAX_LEN;
    localparam int CNT_W   = $clog2(HIST_W + 1);

    logic              bclk_rise;
    logic              slot_close;
    side_e             slot_side;
    logic [HIST_W-1:0] slot_hist;
    logic [CNT_W-1:0]  slot_cnt;
    logic [OUT_W-1:0]  slot_word;
    logic              slot_short;

    adc_rx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (bclk_rise)
    );

    adc_rx_slot #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (bclk_rise),
        .ws         (ws),
        .sd         (sd),
        .close      (slot_close),
        .close_side (slot_side),
        .hist       (slot_hist),
        .cnt        (slot_cnt)
    );

    adc_rx_extract #(.OUT_W(OUT_W), .LEN_W(LEN_W), .HIST_W(HIST_W), .CNT_W(CNT_W)) u_ext (
        .hist       (slot_hist),
        .cnt        (slot_cnt),
        .wlen       (cfg_wlen),
        .wpos       (cfg_wpos),
        .word       (slot_word),
        .short_slot (slot_short)
    );

    typedef struct packed {
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
        logic [OUT_W-1:0] pend;
        logic             pend_ok;
        logic             valid;
        logic             err;
    } pair_t;

    pair_t pr_d, pr_q;

    always_comb begin
        pr_d       = pr_q;
        pr_d.valid = 1'b0;
        pr_d.err   = 1'b0;
        if (slot_close) begin
            pr_d.err = slot_short;
            if (slot_side == SIDE_L) begin
                pr_d.pend    = slot_word;
                pr_d.pend_ok = ~slot_short;
            end else begin
                if (!slot_short && pr_q.pend_ok) begin
                    pr_d.left  = pr_q.pend;
                    pr_d.right = slot_word;
                    pr_d.valid = 1'b1;
                end
                pr_d.pend_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign left_o  = pr_q.left;
    assign right_o = pr_q.right;
    assign valid_o = pr_q.valid;
    assign err_o   = pr_q.err;
endmodule

// File: rtl/adc_rx_chk.sv
module adc_rx_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             close,
    input logic [OUT_W-1:0] left_o,
    input logic [OUT_W-1:0] right_o,
    input logic             valid_o,
    input logic             err_o
);
    p_close_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        close |-> rise);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_after_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(close));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    p_err_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(close));

    p_err_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);
endmodule

bind adc_rx adc_rx_chk #(.OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (bclk_rise),
    .close   (slot_close),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/adc_rx_test.sv
module adc_rx_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [4:0]  cfg_wlen = 5'd15, cfg_wpos = 5'd0;
    logic [31:0] left_o, right_o;
    logic        valid_o, err_o;

    int n_chk = 0, n_fail = 0;
    int exp_err = 0, got_err = 0, exp_valid = 0, got_valid = 0;
    bit done = 0;
    logic [31:0] exp_l[$], exp_r[$];

    adc_rx uut (.clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
                .cfg_wlen(cfg_wlen), .cfg_wpos(cfg_wpos),
                .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] sext(input logic [63:0] w, input int len);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i < len) ? w[i] : w[len-1];
        return r;
    endfunction

    // monitor: compare each strobe against the queued expectation (R3 R4 R5 R6 R8 R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid_o) begin
                got_valid++;
                if (exp_l.size() == 0) begin
                    chk(1'b0, "R6 unexpected valid", 32'd1, 32'd0);
                end else begin
                    logic [31:0] el, er;
                    el = exp_l.pop_front();
                    er = exp_r.pop_front();
                    chk(left_o == el, "R3/R4/R5 left sample", left_o, el);
                    chk(right_o == er, "R3/R4/R5 right sample", right_o, er);
                end
            end
            if (err_o) got_err++;
        end
    end

    task automatic send_bit(input logic side, input logic b);
        @(negedge clk);
        ws = side; sd = b; sck = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sck = 1'b1;
        @(negedge clk);
    endtask

    // build a slot: lead random bits, the word, pos random trailing bits; or a short slot
    task automatic make_slot(input int len, input int pos, input int lead, input bit shrt,
                             output logic [127:0] bits, output int n, output logic [31:0] expw);
        logic [63:0] w;
        logic [127:0] rnd;
        rnd = {$urandom, $urandom, $urandom, $urandom};
        w   = {$urandom, $urandom};
        w   = (len == 64) ? w : (w & ((64'd1 << len) - 64'd1));
        expw = sext(w, len);
        if (shrt) begin
            n = len + pos - 1;
            bits = rnd;
        end else begin
            n = lead + len + pos;
            bits = ((rnd & ((128'd1 << lead) - 128'd1)) << (len + pos))
                 | (128'(w) << pos)
                 | (128'($urandom) & ((128'd1 << pos) - 128'd1));
        end
    endtask

    task automatic send_slot(input logic side, input logic [127:0] bits, input int n,
                             input bit set_cfg, input int len, input int pos);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(side, bits[i]);
            if (set_cfg && i == n - 1) begin
                cfg_wlen = 5'(len - 1);
                cfg_wpos = 5'(pos);
            end
        end
    endtask

    task automatic frame(input int len, input int pos, input int ll, input int lr,
                         input bit sl, input bit sr);
        logic [127:0] bl, br;
        int nl, nr;
        logic [31:0] wl, wr;
        make_slot(len, pos, ll, sl, bl, nl, wl);
        make_slot(len, pos, lr, sr, br, nr, wr);
        if (sl) exp_err++;
        if (sr) exp_err++;
        if (!sl && !sr) begin
            exp_l.push_back(wl);
            exp_r.push_back(wr);
            exp_valid++;
        end
        send_slot(1'b0, bl, nl, 1'b1, len, pos);
        send_slot(1'b1, br, nr, 1'b0, len, pos);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        // R1: reset state, during and after reset
        chk(left_o == 32'd0 && right_o == 32'd0, "R1 samples zero in reset", left_o | right_o, 32'd0);
        chk(!valid_o && !err_o, "R1 strobes low in reset", {30'd0, valid_o, err_o}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!valid_o && !err_o && left_o == 0, "R1 idle after reset", {30'd0, valid_o, err_o}, 32'd0);

        // directed: default 16-bit word filling the slot, R2 R3 R4
        frame(16, 0, 0, 0, 0, 0);
        // full 32-bit word, no skip
        frame(32, 0, 0, 0, 0, 0);
        // 1-bit word with maximum skip
        frame(1, 31, 2, 0, 0, 0);
        // largest placement: 32 + 31 bits
        frame(32, 31, 0, 1, 0, 0);
        // R8: slots over 64 bits with leading noise
        frame(20, 5, 50, 45, 0, 0);
        // R7: short left slot, then short right slot
        frame(12, 3, 0, 0, 1, 0);
        frame(12, 3, 0, 0, 0, 1);
        // R9: config changes back to back
        frame(8, 2, 1, 1, 0, 0);
        frame(24, 7, 0, 3, 0, 0);

        // random frames
        for (int k = 0; k < 40; k++) begin
            int len, pos;
            bit sl, sr;
            len = 1 + int'($urandom_range(31));
            pos = int'($urandom_range(31));
            sl = ($urandom_range(9) == 0) && (len + pos > 1);
            sr = ($urandom_range(9) == 0) && (len + pos > 1);
            frame(len, pos, int'($urandom_range(6)), int'($urandom_range(6)), sl, sr);
        end

        // closing left slot so the last right slot ends
        send_bit(1'b0, 1'b0);
        send_bit(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        chk(got_valid == exp_valid, "R6 valid strobe count", 32'(got_valid), 32'(exp_valid));
        chk(got_err == exp_err, "R7 error strobe count", 32'(got_err), 32'(exp_err));
        chk(exp_l.size() == 0, "R6 pending pairs drained", 32'(exp_l.size()), 32'd0);
        finish_run();
    end
endmodule